// File: doc/BRIEF.md
# DMA Channel Run/Stop Control Register

This block is the per-channel control and status word of a DMA engine, together with the sequencer that starts and stops the channel. Software writes a 32-bit word to start or stop the channel, select the addressing mode and enable a stop interrupt. It reads back the same fields plus two live flags: a request-pending flag that mirrors the peripheral request input, and a stopped flag that reports when the channel is fully idle. The block does not move data. It only grants a burst engine permission to run through `chan_en`, and it watches that engine's `burst_active` level and `burst_done` pulse.

A stop is never abrupt. Clearing the run bit while a burst is in flight moves the sequencer to a draining state. The channel stays enabled until the burst engine reports completion, and only then is the stopped flag raised. The stopped flag is set out of reset. An idle channel with its stop interrupt enabled therefore interrupts at once.

The sequencer has three states. ST_STOPPED is the reset state. ST_RUNNING means run is set and the engine is enabled. ST_DRAINING means run has been cleared and the engine is finishing its current burst. The transitions are:
- START (ST_STOPPED to ST_RUNNING) on an accepted run write.
- HALT (ST_RUNNING to ST_STOPPED) on a run clear with no burst outstanding.
- DRAIN (ST_RUNNING to ST_DRAINING) on a run clear during a burst.
- SETTLE (ST_DRAINING to ST_STOPPED) on `burst_done`.
- RESUME (ST_DRAINING to ST_RUNNING) on a run write during draining.

Top module: `dma_chan_runctl`

## Requirements
- R1: After reset, `rd_data` reads 0x0000_0008 (with `periph_req` low), `chan_en` is 0 and `stop_irq` is 0.
- R2: Writing a word with bit 31 = 1 while stopped starts the channel when either of two conditions holds: bit 30 of that word is 1 (no-descriptor mode), or `desc_addr_valid` is 1. From the cycle after the write, `chan_en` is 1, bit 31 reads 1 and bit 3 reads 0.
- R3: Writing a word with bit 31 = 1 while stopped is ignored for the run field when bit 30 of that word is 0 and `desc_addr_valid` is 0. The channel stays stopped: bit 31 reads 0, bit 3 reads 1 and `chan_en` stays 0. Bits 30 and 29 still take the written values.
- R4: Writing a word with bit 31 = 0 while running stops the channel when `burst_active` is 0, or when `burst_done` is 1 in that cycle. From the next cycle, bit 3 reads 1 and `chan_en` is 0.
- R5: Writing a word with bit 31 = 0 while running, with `burst_active` 1 and `burst_done` 0, keeps `chan_en` at 1 and bit 3 at 0 until a `burst_done` pulse arrives. In the cycle after that pulse, bit 3 reads 1 and `chan_en` is 0. Bit 31 reads 0 throughout the drain.
- R6: Writing bit 31 = 1 while draining returns the channel to running. After that, a `burst_done` pulse does not stop it.
- R7: `stop_irq` is 1 exactly when bit 29 (stop interrupt enable) and bit 3 (stopped) both read 1. This includes a channel that has never been started.
- R8: Bits 30 (mode: 0 = descriptor fetch, 1 = no descriptor) and 29 (stop interrupt enable) read back the last written values.
- R9: Bit 8 reads the current `periph_req` level in the same cycle. Writes to bits 8 and 3 have no effect.
- R10: Bits 28:9, 7:4 and 2:0 always read 0, and writes to them have no effect.
- R11: Writing bit 31 = 1 while running, or a `burst_done` pulse while running, leaves the channel running.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 32 | Register write data |
| rd_data | output | 32 | Register read data (combinational) |
| periph_req | input | 1 | Peripheral request level |
| desc_addr_valid | input | 1 | A descriptor address has been loaded |
| burst_active | input | 1 | Burst engine has a burst in flight |
| burst_done | input | 1 | One-cycle pulse at burst end |
| chan_en | output | 1 | Permission for the burst engine to run |
| stop_irq | output | 1 | Stop interrupt request |

## Verification
Any wrong sequencer state shows up at the ports in the next cycle, because `chan_en` and bits 31 and 3 of `rd_data` are all decoded directly from the state register. A missed DRAIN drops `chan_en` while a burst is still in flight. A missed SETTLE leaves `chan_en` high after `burst_done`. A mode-check error starts or refuses the channel one cycle after the run write. The interrupt output is combinational on the stored enable and the stopped flag, so a wrong interrupt is visible in the same cycle as the state error that causes it.

// File: rtl/dma_runctl_pkg.sv
`timescale 1ns/1ps
package dma_runctl_pkg;
    localparam int REG_W     = 32;
    localparam int RUN_BIT   = 31;
    localparam int MODE_BIT  = 30;
    localparam int IRQEN_BIT = 29;
    localparam int REQ_BIT   = 8;
    localparam int STOP_BIT  = 3;

    typedef enum logic [1:0] {
        ST_STOPPED  = 2'd0,
        ST_RUNNING  = 2'd1,
        ST_DRAINING = 2'd2
    } chan_state_e;
endpackage

// File: rtl/dma_runctl_cfg.sv
`timescale 1ns/1ps
// Plain read/write configuration fields: mode select and stop interrupt enable.
module dma_runctl_cfg (
    input  logic clk,
    input  logic rst_n,
    input  logic wr_en,
    input  logic wr_mode,
    input  logic wr_irqen,
    output logic mode_q,
    output logic irqen_q
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q  <= 1'b0;
            irqen_q <= 1'b0;
        end else if (wr_en) begin
            mode_q  <= wr_mode;
            irqen_q <= wr_irqen;
        end
    end
endmodule

// File: rtl/dma_runctl_seq.sv
`timescale 1ns/1ps
// Run/stop sequencer: STOPPED -> RUNNING -> (DRAINING) -> STOPPED.
module dma_runctl_seq
    import dma_runctl_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_en,
    input  logic        wr_run,
    input  logic        wr_mode,
    input  logic        desc_addr_valid,
    input  logic        burst_active,
    input  logic        burst_done,
    output chan_state_e state_q,
    output logic        run_flag,
    output logic        stopped_flag,
    output logic        chan_en
);
    chan_state_e state_n;
    logic        run_set;
    logic        run_clr;
    logic        start_ok;
    logic        burst_open;

    assign run_set    = wr_en &&  wr_run;
    assign run_clr    = wr_en && !wr_run;
    // No-descriptor mode may start at any time; descriptor mode needs an address.
    assign start_ok   = wr_mode || desc_addr_valid;
    assign burst_open = burst_active && !burst_done;

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_STOPPED;
        else        state_q <= state_n;
    end

    // Next-state logic
    always_comb begin
        state_n = state_q;
        unique case (state_q)
            ST_STOPPED: begin
                if (run_set && start_ok) state_n = ST_RUNNING;      // START
            end
            ST_RUNNING: begin
                if (run_clr) begin
                    if (burst_open) state_n = ST_DRAINING;          // DRAIN
                    else            state_n = ST_STOPPED;           // HALT
                end
            end
            ST_DRAINING: begin
                if (run_set)         state_n = ST_RUNNING;          // RESUME
                else if (burst_done) state_n = ST_STOPPED;          // SETTLE
            end
            default: state_n = ST_STOPPED;
        endcase
    end

    // Outputs
    always_comb begin
        run_flag     = 1'b0;
        stopped_flag = 1'b0;
        chan_en      = 1'b0;
        unique case (state_q)
            ST_STOPPED:  stopped_flag = 1'b1;
            ST_RUNNING: begin
                run_flag = 1'b1;
                chan_en  = 1'b1;
            end
            ST_DRAINING: chan_en = 1'b1;
            default:     stopped_flag = 1'b1;
        endcase
    end
endmodule

// File: rtl/dma_runctl_view.sv
`timescale 1ns/1ps
// Read-word assembly and stop interrupt.
module dma_runctl_view
    import dma_runctl_pkg::*;
(
    input  logic             run_flag,
    input  logic             mode_q,
    input  logic             irqen_q,
    input  logic             periph_req,
    input  logic             stopped_flag,
    output logic [REG_W-1:0] rd_word,
    output logic             stop_irq
);
    always_comb begin
        for (int b = 0; b < REG_W; b++) begin
            unique case (b)
                RUN_BIT:   rd_word[b] = run_flag;
                MODE_BIT:  rd_word[b] = mode_q;
                IRQEN_BIT: rd_word[b] = irqen_q;
                REQ_BIT:   rd_word[b] = periph_req;
                STOP_BIT:  rd_word[b] = stopped_flag;
                default:   rd_word[b] = 1'b0;
            endcase
        end
    end

    assign stop_irq = irqen_q && stopped_flag;
endmodule

// File: rtl/dma_chan_runctl.sv
`timescale 1ns/1ps
module dma_chan_runctl
    import dma_runctl_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [REG_W-1:0]  wr_data,
    output logic [REG_W-1:0]  rd_data,
    input  logic              periph_req,
    input  logic              desc_addr_valid,
    input  logic              burst_active,
    input  logic              burst_done,
    output logic              chan_en,
    output logic              stop_irq
);
    logic        mode_q;
    logic        irqen_q;
    logic        run_flag;
    logic        stopped_flag;
    chan_state_e state_q;

    // Reserved and read-only write bits are dropped here.
    logic unused_wr_bits;
    assign unused_wr_bits = ^{wr_data[IRQEN_BIT-1:0], state_q};

    dma_runctl_cfg u_cfg (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .wr_mode   (wr_data[MODE_BIT]),
        .wr_irqen  (wr_data[IRQEN_BIT]),
        .mode_q    (mode_q),
        .irqen_q   (irqen_q)
    );

    dma_runctl_seq u_seq (
        .clk             (clk),
        .rst_n           (rst_n),
        .wr_en           (wr_en),
        .wr_run          (wr_data[RUN_BIT]),
        .wr_mode         (wr_data[MODE_BIT]),
        .desc_addr_valid (desc_addr_valid),
        .burst_active    (burst_active),
        .burst_done      (burst_done),
        .state_q         (state_q),
        .run_flag        (run_flag),
        .stopped_flag    (stopped_flag),
        .chan_en         (chan_en)
    );

    dma_runctl_view u_view (
        .run_flag     (run_flag),
        .mode_q       (mode_q),
        .irqen_q      (irqen_q),
        .periph_req   (periph_req),
        .stopped_flag (stopped_flag),
        .rd_word      (rd_data),
        .stop_irq     (stop_irq)
    );
endmodule

// File: rtl/dma_chan_runctl_chk.sv
`timescale 1ns/1ps
module dma_chan_runctl_chk (
    input logic clk,
    input logic rst_n,
    input logic wr_en,
    input logic wr_run,
    input logic wr_mode,
    input logic desc_addr_valid,
    input logic burst_active,
    input logic burst_done,
    input logic rd_run,
    input logic rd_stop,
    input logic chan_en,
    input logic stop_irq
);
    AST_START_OK: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_run && (wr_mode || desc_addr_valid) && rd_stop) |=> (chan_en && rd_run && !rd_stop)); // R2

    AST_START_REJECT: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_run && !wr_mode && !desc_addr_valid && rd_stop) |=> (rd_stop && !rd_run && !chan_en)); // R3

    AST_HALT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !wr_run && rd_run && (!burst_active || burst_done)) |=> (rd_stop && !chan_en)); // R4

    AST_DRAIN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (chan_en && !rd_run && !burst_done && !(wr_en && wr_run)) |=> (chan_en && !rd_stop)); // R5

    AST_DRAIN_END: assert property (@(posedge clk) disable iff (!rst_n)
        (chan_en && !rd_run && burst_done && !(wr_en && wr_run)) |=> (rd_stop && !chan_en)); // R5

    AST_RESUME: assert property (@(posedge clk) disable iff (!rst_n)
        (chan_en && !rd_run && wr_en && wr_run) |=> (rd_run && chan_en)); // R6

    AST_IRQ_IDLE_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        stop_irq |-> (!chan_en && rd_stop)); // R7

    AST_KEEP_RUNNING: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_run && !(wr_en && !wr_run)) |=> (rd_run && chan_en)); // R11
endmodule

bind dma_chan_runctl dma_chan_runctl_chk u_chk (
    .clk             (clk),
    .rst_n           (rst_n),
    .wr_en           (wr_en),
    .wr_run          (wr_data[31]),
    .wr_mode         (wr_data[30]),
    .desc_addr_valid (desc_addr_valid),
    .burst_active    (burst_active),
    .burst_done      (burst_done),
    .rd_run          (rd_data[31]),
    .rd_stop         (rd_data[3]),
    .chan_en         (chan_en),
    .stop_irq        (stop_irq)
);

// File: tb/dma_chan_runctl_tb_top.sv
`timescale 1ns/1ps
module dma_chan_runctl_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [31:0] wr_data = '0;
    logic [31:0] rd_data;
    logic        periph_req = 1'b0;
    logic        desc_addr_valid = 1'b0;
    logic        burst_active = 1'b0;
    logic        burst_done = 1'b0;
    logic        chan_en;
    logic        stop_irq;

    int n_checks = 0;
    int n_errors = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    dma_chan_runctl dut_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data),
        .periph_req(periph_req), .desc_addr_valid(desc_addr_valid),
        .burst_active(burst_active), .burst_done(burst_done),
        .chan_en(chan_en), .stop_irq(stop_irq)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s: actual=0x%08h expected=0x%08h", tag, act, exp);
        end
    endtask

    // Drive at a falling edge, let one rising edge take it, sample at the next falling edge.
    task automatic reg_write(input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0; wr_data = '0;
    endtask

    task automatic done_pulse();
        @(negedge clk);
        burst_done = 1'b1; burst_active = 1'b0;
        @(negedge clk);
        burst_done = 1'b0;
    endtask

    task automatic t_reset();
        chk("R1 rd_data", rd_data, 32'h0000_0008);
        chk("R1 chan_en", {31'b0, chan_en}, 32'd0);
        chk("R1 stop_irq", {31'b0, stop_irq}, 32'd0);
    endtask

    task automatic t_irq_idle();
        reg_write(32'h2000_0000);
        chk("R7 irq on never-started channel", {31'b0, stop_irq}, 32'd1);
        chk("R8 enable readback", rd_data, 32'h2000_0008);
        reg_write(32'h0000_0000);
        chk("R7 irq cleared", {31'b0, stop_irq}, 32'd0);
    endtask

    task automatic t_desc_reject();
        desc_addr_valid = 1'b0;
        reg_write(32'hA000_0000);
        chk("R3 run ignored", rd_data, 32'h2000_0008);
        chk("R3 chan_en low", {31'b0, chan_en}, 32'd0);
        reg_write(32'h0000_0000);
    endtask

    task automatic t_start_desc_and_hold();
        desc_addr_valid = 1'b1;
        reg_write(32'h8000_0000);
        desc_addr_valid = 1'b0;
        chk("R2 start desc mode", rd_data, 32'h8000_0000);
        chk("R2 chan_en high", {31'b0, chan_en}, 32'd1);
        reg_write(32'h8000_0000);
        done_pulse();
        chk("R11 stays running", {rd_data[31], rd_data[3], 29'b0, chan_en}, {1'b1, 1'b0, 29'b0, 1'b1});
    endtask

    task automatic t_stop_idle();
        burst_active = 1'b0;
        reg_write(32'h2000_0000);
        chk("R4 stopped next cycle", rd_data, 32'h2000_0008);
        chk("R4 chan_en low", {31'b0, chan_en}, 32'd0);
        chk("R7 irq after stop", {31'b0, stop_irq}, 32'd1);
        reg_write(32'h0000_0000);
    endtask

    task automatic t_drain();
        reg_write(32'hC000_0000);
        chk("R2 start no-desc mode", rd_data, 32'hC000_0000);
        burst_active = 1'b1;
        reg_write(32'h4000_0000);
        chk("R5 draining flags", rd_data, 32'h4000_0000);
        chk("R5 chan_en held", {31'b0, chan_en}, 32'd1);
        repeat (3) @(negedge clk);
        chk("R5 still draining", {31'b0, chan_en}, 32'd1);
        done_pulse();
        chk("R5 stopped after done", rd_data, 32'h4000_0008);
        chk("R5 chan_en low", {31'b0, chan_en}, 32'd0);
    endtask

    task automatic t_resume();
        reg_write(32'hC000_0000);
        burst_active = 1'b1;
        reg_write(32'h4000_0000);
        reg_write(32'hC000_0000);
        chk("R6 resumed", rd_data, 32'hC000_0000);
        done_pulse();
        chk("R6 done ignored", {31'b0, chan_en}, 32'd1);
        chk("R6 run kept", rd_data, 32'hC000_0000);
        reg_write(32'h4000_0000);
        chk("R4 stop after resume", rd_data, 32'h4000_0008);
    endtask

    task automatic t_fields();
        reg_write(32'h7FFF_FFFF);
        chk("R10 reserved read zero", rd_data, 32'h6000_0008);
        reg_write(32'h0000_0108);
        chk("R9 read-only bits ignored", rd_data, 32'h0000_0008);
        periph_req = 1'b1;
        #1;
        chk("R9 request pending", rd_data, 32'h0000_0108);
        periph_req = 1'b0;
        #1;
        chk("R9 request cleared", rd_data, 32'h0000_0008);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_irq_idle();
        t_desc_reject();
        t_start_desc_and_hold();
        t_stop_idle();
        t_drain();
        t_resume();
        t_fields();
        if (!finished) begin
            finished = 1'b1;
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end

    initial begin
        #1_000_000;
        if (!finished) begin
            finished = 1'b1;
            n_checks++;
            n_errors++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end
endmodule